// File: doc/BRIEF.md
# Macroblock Slot Sequencer

This block sits between a bitstream parser and a macroblock decoder. It takes macroblock records from the parser over a valid/ready interface. A record is one header beat followed by zero or more payload beats. The header beat carries the picture position (group number and macroblock number) and the control byte. The block replays each record as a stream of bytes on an 8-bit bus. Every byte has a 4-bit tag that tells the decoder what the byte holds.

Byte transfers follow a free-running strobe at half the clock rate, so one byte goes out every two clocks. Each macroblock gets a slot of at least `SLOT_CLKS` clocks, and idle bytes fill whatever time is left. The block tracks the picture position itself. When the next record does not belong to the position that follows the last one sent, the block first fills every missing position with a dummy fixed macroblock. This gap may run past the end of a picture and wrap into the next one.

Idle bytes are not always empty. A second valid/ready channel can place picture-level side parameters in them, each marked with a 3-bit auxiliary tag.

Top module: `mb_slot_sequencer`

## Requirements
- R1: `strobe_o` toggles on every clock. `out_byte`, `out_tag` and `aux_tag` change only on the edge where `strobe_o` falls, and hold for the two clocks that follow.
- R2: `out_tag` uses these codes: 0000 group number, 0001 macroblock number, 0010 control byte, 0011 quantizer, 0100 horizontal vector, 0101 vertical vector, 0110 coded block pattern, 0111 sub-block number, 1000 zero run, 1001 coefficient, 1111 idle. A payload beat goes out with its upstream `in_mode` unchanged.
- R3: A slot sends three bytes in a row: the control byte (tag 0010), then the group number (tag 0000), then the macroblock number (tag 0001). The record's payload beats follow in arrival order.
- R4: Two slot starts (control bytes) are at least `SLOT_CLKS` clocks apart. When the next slot's content is already waiting, they are exactly `SLOT_CLKS` apart.
- R5: A real record's control byte is sent unchanged. Its bit 0 marks a fixed macroblock, bit 1 inter coding, bit 2 loop filter, bit 3 motion compensation and bit 7 the full-size picture format.
- R6: Every missing position gets a dummy slot. Its control byte has bit 0 = 1, bit 7 = `cif_mode` and all other bits 0, which means intra coding. A dummy slot has no payload. While dummies are being sent, `in_ready` stays low and the waiting header is held.
- R7: A gap that crosses the end of a picture is filled through the picture boundary, and position numbering restarts at the first group.
- R8: Macroblocks are numbered 1 to 33 within a group. With `cif_mode`=1 the groups run 1 to 12. With `cif_mode`=0 they run 1, 3, 5.
- R9: After reset the output is idle (tag 1111, auxiliary tag 111, byte 0). The current position is group 12, macroblock 33, so group 1, macroblock 1 follows with no dummies.
- R10: Side items appear only on idle bytes, one per byte, in order, with `aux_tag` = `side_tag` (000 temporal reference, 001 group spare, 010 picture spare, 011 picture type, 100 quantizer step). Every non-idle byte carries `aux_tag` = 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cif_mode | input | 1 | 1 = 12-group picture, 0 = 3-group picture |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Upstream beat accepted this clock |
| in_start | input | 1 | Beat is a record header |
| in_gob | input | GW (4) | Header group number |
| in_mb | input | MW (6) | Header macroblock number |
| in_mode | input | 4 | Payload beat tag |
| in_data | input | 8 | Control byte (header) or payload byte |
| in_last | input | 1 | Last beat of the record |
| side_valid | input | 1 | Side item valid |
| side_ready | output | 1 | Side item accepted this clock |
| side_tag | input | 3 | Side item kind |
| side_data | input | 8 | Side item value |
| strobe_o | output | 1 | Byte strobe, clock divided by two |
| out_byte | output | 8 | Output byte |
| out_tag | output | 4 | Output byte tag |
| aux_tag | output | 3 | Side item tag, 111 when unused |

## Verification
Two functions compete for the same byte period. A slot start, or a dummy insertion, can fall in the same byte period in which a side item is waiting for the bus. The bench provokes this by sending side items from a concurrent process while records with gaps are being sent. Each byte is then judged by its tags: a control, group or macroblock byte must carry auxiliary tag 111 and match the expected record or dummy in order, and each side item must surface on an idle byte in the order it was offered. Dummy runs are also timed, so that slots back to back land exactly one slot period apart.

// File: rtl/mb_slot_sequencer.sv
`timescale 1ns/1ps
module mb_slot_sequencer #(
  parameter int SLOT_CLKS  = 2048,
  parameter int MB_PER_GOB = 33,
  parameter int GOBS_CIF   = 12,
  parameter int GOBS_QCIF  = 3,
  localparam int GW = $clog2(GOBS_CIF + 1),
  localparam int MW = $clog2(MB_PER_GOB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cif_mode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_start,
  input  logic [GW-1:0] in_gob,
  input  logic [MW-1:0] in_mb,
  input  logic [3:0]    in_mode,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          side_valid,
  output logic          side_ready,
  input  logic [2:0]    side_tag,
  input  logic [7:0]    side_data,
  output logic          strobe_o,
  output logic [7:0]    out_byte,
  output logic [3:0]    out_tag,
  output logic [2:0]    aux_tag
);
  localparam int SLOT_BYTES = SLOT_CLKS / 2;
  localparam int BW = $clog2(SLOT_BYTES + 1);
  localparam int SW = $clog2(SLOT_CLKS + 1);
  localparam int QCIF_LAST = 2 * GOBS_QCIF - 1;
  localparam logic [3:0] TG_GOB = 4'h0, TG_MB = 4'h1, TG_CTRL = 4'h2, TG_IDLE = 4'hF;
  localparam logic [2:0] AX_NONE = 3'b111;

  typedef enum logic [1:0] {ST_IDLE, ST_GOB, ST_MB, ST_PAY} st_t;

  st_t           state;
  logic          ph, more;
  logic [BW-1:0] bcnt;
  logic [GW-1:0] cur_gob, nxt_gob;
  logic [MW-1:0] cur_mb, nxt_mb;

  always_comb begin
    nxt_gob = cur_gob;
    nxt_mb  = cur_mb + MW'(1);
    if (cur_mb >= MW'(MB_PER_GOB)) begin
      nxt_mb = MW'(1);
      if (cif_mode) nxt_gob = (cur_gob >= GW'(GOBS_CIF)) ? GW'(1) : cur_gob + GW'(1);
      else          nxt_gob = (cur_gob >= GW'(QCIF_LAST)) ? GW'(1) : cur_gob + GW'(2);
    end
  end

  wire tick      = ph;
  wire slot_open = (bcnt == BW'(SLOT_BYTES));
  wire hdr_match = (in_gob == nxt_gob) && (in_mb == nxt_mb);
  wire start_now = (state == ST_IDLE) && slot_open && in_valid && in_start;
  wire take_hdr  = start_now && hdr_match;
  wire take_pay  = (state == ST_PAY) && in_valid;
  wire idle_byte = !start_now && ((state == ST_IDLE) || (state == ST_PAY && !in_valid));

  assign in_ready   = tick && (take_hdr || take_pay);
  assign side_ready = tick && idle_byte;
  assign strobe_o   = ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= 1'b0;
      state    <= ST_IDLE;
      more     <= 1'b0;
      bcnt     <= BW'(SLOT_BYTES);
      cur_gob  <= GW'(GOBS_CIF);
      cur_mb   <= MW'(MB_PER_GOB);
      out_byte <= 8'h00;
      out_tag  <= TG_IDLE;
      aux_tag  <= AX_NONE;
    end else begin
      ph <= ~ph;
      if (tick) begin
        if (!slot_open) bcnt <= bcnt + BW'(1);
        out_byte <= 8'h00;
        out_tag  <= TG_IDLE;
        aux_tag  <= AX_NONE;
        case (state)
          ST_IDLE: if (start_now) begin
            bcnt     <= BW'(1);
            cur_gob  <= nxt_gob;
            cur_mb   <= nxt_mb;
            out_tag  <= TG_CTRL;
            out_byte <= hdr_match ? in_data : {cif_mode, 6'b0, 1'b1};
            more     <= hdr_match && !in_last;
            state    <= ST_GOB;
          end
          ST_GOB: begin
            out_tag  <= TG_GOB;
            out_byte <= 8'(cur_gob);
            state    <= ST_MB;
          end
          ST_MB: begin
            out_tag  <= TG_MB;
            out_byte <= 8'(cur_mb);
            state    <= more ? ST_PAY : ST_IDLE;
          end
          ST_PAY: if (in_valid) begin
            out_tag  <= in_mode;
            out_byte <= in_data;
            if (in_last) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
        if (idle_byte && side_valid) begin
          aux_tag  <= side_tag;
          out_byte <= side_data;
        end
      end
    end
  end

  logic [SW-1:0] since_ctrl;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_ctrl <= SW'(SLOT_CLKS);
    else if (tick && start_now) since_ctrl <= '0;
    else if (since_ctrl < SW'(SLOT_CLKS)) since_ctrl <= since_ctrl + SW'(1);
  end

  AST_STROBE_FALL: assert property (@(posedge clk) disable iff (!rst_n) strobe_o |=> !strobe_o); // R1
  AST_STROBE_RISE: assert property (@(posedge clk) disable iff (!rst_n) !strobe_o |=> strobe_o); // R1
  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_o |=> $stable(out_byte) && $stable(out_tag) && $stable(aux_tag)); // R1
  AST_SLOT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && start_now) |-> since_ctrl >= SW'(SLOT_CLKS - 1)); // R4
  AST_CTRL_THEN_GOB: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o && out_tag == TG_CTRL) |=> out_tag == TG_GOB); // R3
  AST_GOB_THEN_MB: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o && out_tag == TG_GOB) |=> out_tag == TG_MB); // R3
  AST_AUX_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    aux_tag != AX_NONE |-> out_tag == TG_IDLE); // R10
  AST_MB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_tag == TG_MB |-> (out_byte >= 8'd1 && out_byte <= 8'(MB_PER_GOB))); // R8
  AST_GOB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_tag == TG_GOB |-> (out_byte >= 8'd1 && out_byte <= 8'(GOBS_CIF))); // R8
endmodule

// File: tb/tb_mb_slot_sequencer.sv
`timescale 1ns/1ps
module tb_mb_slot_sequencer;
  localparam int SLOT = 32;

  logic clk = 1'b0, rst_n = 1'b0, cif_mode = 1'b1;
  logic in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0;
  logic [3:0] in_gob = '0, in_mode = '0;
  logic [5:0] in_mb = '0;
  logic [7:0] in_data = '0, side_data = '0;
  logic side_valid = 1'b0;
  logic [2:0] side_tag = '0;
  logic in_ready, side_ready, strobe_o;
  logic [7:0] out_byte;
  logic [3:0] out_tag;
  logic [2:0] aux_tag;

  mb_slot_sequencer #(.SLOT_CLKS(SLOT)) dut (
    .clk(clk), .rst_n(rst_n), .cif_mode(cif_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_start(in_start),
    .in_gob(in_gob), .in_mb(in_mb), .in_mode(in_mode), .in_data(in_data), .in_last(in_last),
    .side_valid(side_valid), .side_ready(side_ready), .side_tag(side_tag), .side_data(side_data),
    .strobe_o(strobe_o), .out_byte(out_byte), .out_tag(out_tag), .aux_tag(aux_tag));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [11:0] mq[$];
  string mr[$];
  logic [10:0] sq[$];
  int bg = 12, bm = 33;
  int prev_ctrl = -1;
  bit prev_dummy = 0;
  logic [18:0] last_seen = '0;
  bit mon_on = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [3:0] md, logic [7:0] d, string r);
    mq.push_back({md, d});
    mr.push_back(r);
  endtask

  task automatic adv();
    if (bm >= 33) begin
      bm = 1;
      if (cif_mode) bg = (bg >= 12) ? 1 : bg + 1;
      else          bg = (bg >= 5) ? 1 : bg + 2;
    end else bm++;
  endtask

  task automatic beat(bit st, int g, int m, logic [3:0] md, logic [7:0] d, bit last);
    @(negedge clk);
    in_valid = 1'b1; in_start = st; in_gob = g[3:0]; in_mb = m[5:0];
    in_mode = md; in_data = d; in_last = last;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_mb(int g, int m, logic [7:0] ctrl, int n, string rtag);
    adv();
    while (!(bg == g && bm == m)) begin
      push(4'h2, {cif_mode, 6'b0, 1'b1}, "R6");
      push(4'h0, 8'(bg), "R7");
      push(4'h1, 8'(bm), "R8");
      adv();
    end
    push(4'h2, ctrl, rtag);
    push(4'h0, 8'(g), "R3");
    push(4'h1, 8'(m), "R3");
    for (int i = 0; i < n; i++) push(4'(3 + i % 7), 8'(g * 16 + i), "R2");
    beat(1'b1, g, m, 4'h0, ctrl, n == 0);
    for (int i = 0; i < n; i++) beat(1'b0, g, m, 4'(3 + i % 7), 8'(g * 16 + i), i == n - 1);
  endtask

  task automatic side_put(logic [2:0] t, logic [7:0] d);
    sq.push_back({t, d});
    @(negedge clk);
    side_valid = 1'b1; side_tag = t; side_data = d;
    forever begin
      #1;
      if (side_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1 side_valid = 1'b0;
  endtask

  task automatic side_burst(int count, int base);
    for (int i = 0; i < count; i++) begin
      side_put(3'(i % 5), 8'(base + i));
      repeat (i % 3 + 1) @(negedge clk);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (strobe_o) begin
        chk({out_tag, aux_tag, out_byte} == last_seen, "R1", "byte changed mid-period",
            {out_tag, aux_tag, out_byte}, last_seen);
      end else begin
        last_seen = {out_tag, aux_tag, out_byte};
        if (out_tag != 4'hF) begin
          chk(aux_tag == 3'b111, "R10", "aux tag on data byte", aux_tag, 7);
          if (mq.size() == 0) chk(0, "R3", "unexpected byte", {out_tag, out_byte}, 0);
          else begin
            logic [11:0] e;
            string r;
            e = mq.pop_front();
            r = mr.pop_front();
            chk({out_tag, out_byte} == e, r, "byte", {out_tag, out_byte}, e);
          end
          if (out_tag == 4'h2) begin
            if (prev_ctrl >= 0) begin
              chk(cyc - prev_ctrl >= SLOT, "R4", "slot spacing", cyc - prev_ctrl, SLOT);
              if (prev_dummy) chk(cyc - prev_ctrl == SLOT, "R4", "back-to-back spacing", cyc - prev_ctrl, SLOT);
            end
            prev_ctrl = cyc;
            prev_dummy = out_byte[0];
          end
        end else if (aux_tag != 3'b111) begin
          if (sq.size() == 0) chk(0, "R10", "unexpected side item", {aux_tag, out_byte}, 0);
          else begin
            logic [10:0] s;
            s = sq.pop_front();
            chk({aux_tag, out_byte} == s, "R10", "side item", {aux_tag, out_byte}, s);
          end
        end
      end
    end
  end

  task automatic drain();
    while (mq.size() != 0 || sq.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_tag == 4'hF, "R9", "reset tag", out_tag, 4'hF);
    chk(aux_tag == 3'b111, "R9", "reset aux tag", aux_tag, 7);
    chk(out_byte == 8'h00, "R9", "reset byte", out_byte, 0);
    chk(in_ready == 1'b0, "R9", "ready with no input", in_ready, 0);
    for (int i = 0; i < 4; i++) begin
      logic a;
      a = strobe_o;
      @(negedge clk);
      chk(strobe_o != a, "R1", "strobe toggle", strobe_o, !a);
    end
    while (strobe_o) @(negedge clk);
    last_seen = {out_tag, aux_tag, out_byte};
    mon_on = 1;

    send_mb(1, 1, 8'h8A, 2, "R9");
    fork
      begin
        send_mb(1, 2, 8'h86, 5, "R5");
        send_mb(1, 5, 8'h8E, 0, "R6");
        send_mb(1, 33, 8'h82, 1, "R5");
        send_mb(2, 1, 8'h84, 3, "R8");
      end
      side_burst(8, 8'hA0);
    join
    send_mb(12, 33, 8'h80, 0, "R8");
    send_mb(1, 1, 8'h88, 1, "R7");
    send_mb(1, 3, 8'h8A, 0, "R6");
    send_mb(1, 2, 8'h82, 2, "R7");
    send_mb(1, 3, 8'h86, 20, "R4");
    send_mb(1, 4, 8'h80, 0, "R4");
    drain();
    @(negedge clk) cif_mode = 1'b0;
    fork
      send_mb(3, 1, 8'h0A, 1, "R8");
      side_burst(5, 8'hC0);
    join
    send_mb(1, 1, 8'h02, 0, "R7");
    drain();
    repeat (SLOT) @(negedge clk);
    chk(mq.size() == 0, "R3", "bytes left", mq.size(), 0);
    chk(sq.size() == 0, "R10", "side items left", sq.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R3 actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule